// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address stream for a four-beat burst. When a burst begins, it captures a full external address. On each following continue cycle it moves the two low address bits to the next beat position. The upper bits keep the captured value for the whole burst. The output is the full current address. It is read directly from the block's registers, so a capture or a step shows at the output one clock after the edge that performs it.

A mode input sets the beat order, and it is normally tied to one level.

- **Interleaved order (mode high):** the low bits are the start offset XOR a running beat number.
- **Linear order (mode low):** the low bits are the start offset plus the beat number, wrapped modulo four.

The beat number is two bits wide. Every fourth step therefore brings the address back to the start value.

A hold input freezes the sequencer for a cycle. While it is high, no input changes the address. A single select input decides what each unfrozen cycle does: low captures a new address, high steps the burst. Stepping happens on every continue cycle, whether or not an access is actually performed on that beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer clears. After reset, `cur_addr` is 0.
- R2: A clock edge with `stall`=0 and `advance`=0 captures `ext_addr`. From the next cycle, `cur_addr` equals that value in all bits.
- R3: With `ilv_order`=1, after k steps since the last capture, `cur_addr[1:0]` equals the captured low bits XOR (k mod 4). From start 01 the sequence is 01, 00, 11, 10.
- R4: With `ilv_order`=0, after k steps since the last capture, `cur_addr[1:0]` equals (captured low bits + k) mod 4. From start 01 the sequence is 01, 10, 11, 00.
- R5: After exactly four steps following a capture, `cur_addr` equals the captured address again, in either order.
- R6: Steps never change `cur_addr[ADDR_W-1:2]`. For example, in linear order a step from low bits 11 gives 00 with no carry into bit 2.
- R7: A clock edge with `stall`=1 leaves `cur_addr` unchanged, whatever the values of `advance` and `ext_addr`.
- R8: On a step cycle (`stall`=0, `advance`=1), the value of `ext_addr` has no effect on `cur_addr`.
- R9: A capture in the middle of a burst restarts the beat number at zero. The next step then yields the new start offset combined with beat 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High: hold all state for this cycle |
| advance | input | 1 | Low: capture `ext_addr`; high: step the burst |
| ilv_order | input | 1 | Beat order: 1 interleaved (XOR), 0 linear (add modulo 4) |
| ext_addr | input | ADDR_W | External address captured at the start of a burst |
| cur_addr | output | ADDR_W | Current burst address |

## Verification
The assertions assume that `ilv_order` changes only on a capture cycle, never in the middle of a burst or during a stall. The wrap and linear-step checks relate addresses across a whole burst, so they depend on this. They also assume all inputs are known after reset.

The random part of the bench follows these rules:
- It draws a new order value only on the cycles where it issues a capture.
- Between captures it freely mixes stalls, steps and arbitrary values on `ext_addr`.

The directed part walks all four start offsets in both orders, crosses the all-ones upper field, and reloads partway through a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Hold wins over everything; otherwise the select pin chooses.
    function automatic seq_op_e pick_op(input logic stall, input logic advance);
        if (stall)
            return OP_HOLD;
        else if (advance)
            return OP_STEP;
        else
            return OP_LOAD;
    endfunction

    function automatic ofs_t xor_ofs(input ofs_t start, input ofs_t beat);
        return start ^ beat;
    endfunction

    function automatic ofs_t add_ofs(input ofs_t start, input ofs_t beat);
        return ofs_t'(start + beat);
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_op_e op,
    output ofs_t    beat
);

    ofs_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: beat_q <= '0;
                OP_STEP: beat_q <= ofs_t'(beat_q + 1'b1);
                default: beat_q <= beat_q;
            endcase
        end
    end

    assign beat = beat_q;

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_op_e           op,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base
);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (op == OP_LOAD)
            base_q <= ext_addr;
    end

    assign base = base_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  order_e ord,
    input  ofs_t   start,
    input  ofs_t   beat,
    output ofs_t   ofs
);

    always_comb begin
        unique case (ord)
            ORD_XOR:    ofs = xor_ofs(start, beat);
            default:    ofs = add_ofs(start, beat);
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              advance,
    input  logic              ilv_order,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int UP_W = ADDR_W - OFS_W;

    seq_op_e           op;
    ofs_t              beat;
    ofs_t              ofs;
    logic [ADDR_W-1:0] base;

    assign op = pick_op(stall, advance);

    burst_beat_ctr u_beat (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .beat (beat)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ext_addr (ext_addr),
        .base     (base)
    );

    burst_order_map u_map (
        .ord   (order_e'(ilv_order)),
        .start (base[OFS_W-1:0]),
        .beat  (beat),
        .ofs   (ofs)
    );

    generate
        if (UP_W > 0) begin : g_upper
            assign cur_addr = {base[ADDR_W-1:OFS_W], ofs};
        end else begin : g_low_only
            assign cur_addr = ofs;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              advance,
    input logic              ilv_order,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] cur_addr
);

    logic [1:0]        steps_q;
    logic [ADDR_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            steps_q <= '0;
            start_q <= '0;
        end else if (!stall && !advance) begin
            steps_q <= '0;
            start_q <= ext_addr;
        end else if (!stall) begin
            steps_q <= steps_q + 2'd1;
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !advance) |=> cur_addr == $past(ext_addr));

    // R7
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(cur_addr) || !$stable(ilv_order)));

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance) |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance && !ilv_order) |=>
            (!$stable(ilv_order) || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    // R3
    xor_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance && ilv_order) |=>
            (!$stable(ilv_order) || cur_addr[0] != $past(cur_addr[0])));

    // R5
    wrap_home_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance && steps_q == 2'd3) |=> cur_addr == start_q);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .advance   (advance),
    .ilv_order (ilv_order),
    .ext_addr  (ext_addr),
    .cur_addr  (cur_addr)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic          advance = 1'b0;
    logic          ilv_order = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .advance   (advance),
        .ilv_order (ilv_order),
        .ext_addr  (ext_addr),
        .cur_addr  (cur_addr)
    );

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] base,
                                                  input logic [1:0] beat,
                                                  input logic mode);
        logic [1:0] lo;
        lo = mode ? (base[1:0] ^ beat) : 2'(base[1:0] + beat);
        return {base[AW-1:2], lo};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (cur_addr !== exp) begin
            errors++;
            $display("FAIL %s: cur_addr=%h expected=%h", tag, cur_addr, exp);
        end
    endtask

    task automatic drive(input logic s, input logic a, input logic m,
                         input logic [AW-1:0] x, input string tag);
        @(negedge clk);
        stall = s; advance = a; ilv_order = m; ext_addr = x;
        @(posedge clk);
        #1;
        if (!s) begin
            if (!a) begin
                m_base = x;
                m_beat = 2'd0;
            end else begin
                m_beat = m_beat + 2'd1;
            end
        end
        check(tag, expect_addr(m_base, m_beat, m));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] start;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", '0);

        // R2 R3 R4 R5 R8: every start offset in both orders
        for (int m = 1; m >= 0; m--) begin
            for (int s = 0; s < 4; s++) begin
                start = {AW'($urandom) >> 2, 2'(s)};
                start[1:0] = 2'(s);
                drive(1'b0, 1'b0, 1'(m), start, "R2");
                for (int k = 1; k <= 4; k++) begin
                    drive(1'b0, 1'b1, 1'(m), AW'($urandom),
                          k == 4 ? "R5" : (m == 1 ? "R3" : "R4"));
                end
            end
        end

        // R3/R4 documented sequences from start 01
        drive(1'b0, 1'b0, 1'b1, 17'h00A51, "R2");
        drive(1'b0, 1'b1, 1'b1, '0, "R3");
        check("R3", 17'h00A50);
        drive(1'b0, 1'b1, 1'b1, '0, "R3");
        check("R3", 17'h00A53);
        drive(1'b0, 1'b0, 1'b0, 17'h00A51, "R2");
        drive(1'b0, 1'b1, 1'b0, '0, "R4");
        check("R4", 17'h00A52);

        // R6: no carry out of the low field
        drive(1'b0, 1'b0, 1'b0, 17'h1FFFF, "R2");
        drive(1'b0, 1'b1, 1'b0, 17'h00000, "R6");
        check("R6", 17'h1FFFC);
        drive(1'b0, 1'b0, 1'b0, 17'h0BEE7, "R2");
        drive(1'b0, 1'b1, 1'b0, 17'h1FFFF, "R6");
        check("R6", 17'h0BEE4);

        // R7: stall with step select and with load select
        drive(1'b0, 1'b0, 1'b1, 17'h12342, "R2");
        drive(1'b0, 1'b1, 1'b1, '0, "R3");
        drive(1'b1, 1'b1, 1'b1, 17'h1FFFF, "R7");
        check("R7", 17'h12343);
        drive(1'b1, 1'b0, 1'b1, 17'h05555, "R7");
        check("R7", 17'h12343);
        drive(1'b0, 1'b1, 1'b1, 17'h05555, "R8");
        check("R8", 17'h12340);

        // R9: reload mid-burst restarts the beat number
        drive(1'b0, 1'b0, 1'b1, 17'h00302, "R2");
        drive(1'b0, 1'b1, 1'b1, '0, "R3");
        drive(1'b0, 1'b1, 1'b1, '0, "R3");
        drive(1'b0, 1'b0, 1'b1, 17'h00701, "R9");
        drive(1'b0, 1'b1, 1'b1, '0, "R9");
        check("R9", 17'h00700);

        // Random mix; order redrawn only on capture cycles
        begin
            logic mode;
            mode = 1'b1;
            for (int i = 0; i < 600; i++) begin
                logic s, a;
                s = ($urandom % 5) == 0;
                a = ($urandom % 4) != 0;
                if (!s && !a) begin
                    mode = 1'($urandom);
                    drive(s, a, mode, AW'($urandom), "R2");
                end else if (s) begin
                    drive(s, a, mode, AW'($urandom), "R7");
                end else begin
                    drive(s, a, mode, AW'($urandom), mode ? "R3" : "R4");
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule